// File: doc/BRIEF.md
# Wrapping Bit-Field Extract Unit

This datapath unit pulls a contiguous group of bits out of a source word and returns it right-aligned. The caller gives the position of the field's lowest bit and the field's width. A field that runs past the top bit continues from bit zero, so the unit behaves like a right rotation by the start position followed by keeping the low `width` bits. A mode bit chooses between zero extension and sign extension of the field. A size select chooses 32-bit or 64-bit operation.

Each accepted operation (input valid high) produces a result, a zero flag and a sign flag one clock later, together with an output valid strobe. In 32-bit mode only the low halves of the source and the low five bits of the position and width count, and the upper half of the result reads zero. A width that masks to zero has a defined result of zero.

Top module: `bitfield_extract`

## Requirements
- R1: With sign_ext low, result bit i equals src bit ((shift + i) mod N) for i below the masked width, and every result bit from the masked width upward is 0, where N is 64 when size_full is 1 and 32 when size_full is 0.
- R2: A field whose start plus width exceeds N continues from source bit 0 upward; bits above N-1 are never used.
- R3: With sign_ext high, all result bits from the masked width up to N-1 equal the field's top bit.
- R4: In 32-bit mode bit 5 of shift and of width and bits 63:32 of src have no effect on the result or the flags.
- R5: When the masked width is 0 the result is 0 and the zero flag is 1, in either extension mode.
- R6: zero_flag is 1 exactly when the result is all zeros.
- R7: sign_flag equals result bit N-1 (bit 63 in 64-bit mode, bit 31 in 32-bit mode).
- R8: In 32-bit mode result bits 63:32 are 0.
- R9: Synchronous active-high reset clears out_valid, result and flags; out_valid is high in the cycle after each clock edge where in_valid is high and low otherwise.
- R10: An edge with in_valid low leaves result and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation accepted on this edge |
| src | input | 64 | Source word |
| shift | input | 6 | Position of the field's lowest bit |
| width | input | 6 | Field width in bits |
| size_full | input | 1 | 1 for 64-bit, 0 for 32-bit operation |
| sign_ext | input | 1 | 1 for sign extension, 0 for zero extension |
| result | output | 64 | Extracted, right-aligned field |
| zero_flag | output | 1 | Result is zero |
| sign_flag | output | 1 | Top bit of result at selected size |
| out_valid | output | 1 | Result and flags hold a new operation |

## Verification
Every result, both flags and out_valid are due exactly one clock edge after the edge that accepts the operation. The bench drives each operation on a falling edge and compares all outputs on the following falling edge, after the single register stage has updated and before the next operation is taken. The hold check idles in_valid for two edges and reads the outputs after each, and the reset check reads them on the falling edge after the reset edge.

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
  parameter int W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [W-1:0]         src,
  input  logic [$clog2(W)-1:0] shift,
  input  logic [$clog2(W)-1:0] width,
  input  logic                 size_full,
  input  logic                 sign_ext,
  output logic [W-1:0]         result,
  output logic                 zero_flag,
  output logic                 sign_flag,
  output logic                 out_valid
);
  localparam int HW = W / 2;
  localparam int SW = $clog2(W);

  logic [SW-1:0]   sh_m, wd_m, top_idx;
  logic [2*W-1:0]  dbl_full;
  logic [W-1:0]    dbl_half;
  logic [W-1:0]    rot, low_mask, size_mask, nxt;
  logic            size_q, sgn_q;
  logic [SW-1:0]   wd_q;

  assign sh_m = size_full ? shift : {1'b0, shift[SW-2:0]};
  assign wd_m = size_full ? width : {1'b0, width[SW-2:0]};
  assign top_idx = wd_m - 1'b1;

  assign dbl_full = {src, src} >> sh_m;
  assign dbl_half = {src[HW-1:0], src[HW-1:0]} >> sh_m;
  assign rot = size_full ? dbl_full[W-1:0] : {{HW{1'b0}}, dbl_half[HW-1:0]};

  assign low_mask  = ~({W{1'b1}} << wd_m);
  assign size_mask = size_full ? {W{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

  always_comb begin
    nxt = rot & low_mask;
    if (sign_ext && rot[top_idx])
      nxt = nxt | (~low_mask & size_mask);
    if (wd_m == '0)
      nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      zero_flag <= 1'b0;
      sign_flag <= 1'b0;
      size_q    <= 1'b0;
      sgn_q     <= 1'b0;
      wd_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt;
        zero_flag <= (nxt == '0);
        sign_flag <= size_full ? nxt[W-1] : nxt[HW-1];
        size_q    <= size_full;
        sgn_q     <= sign_ext;
        wd_q      <= wd_m;
      end
    end
  end

  p_unsigned_high_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !sgn_q && wd_q != '0 |-> (result >> wd_q) == '0);
  p_zero_width_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && wd_m == '0 |=> result == '0 && zero_flag);
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> zero_flag == (result == '0));
  p_sign_flag_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sign_flag == (size_q ? result[W-1] : result[HW-1]));
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !size_q |-> result[W-1:HW] == '0);
  p_valid_next_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !rst |=> $stable(result) && $stable(zero_flag) && !out_valid);
endmodule

// File: tb/bitfield_extract_tb.sv
`timescale 1ns/1ps
module bitfield_extract_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] src;
  logic [5:0]  shift, width;
  logic        size_full, sign_ext;
  logic [63:0] result;
  logic        zero_flag, sign_flag, out_valid;

  int checks = 0;
  int failures = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  bitfield_extract #(.W(64)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .shift(shift),
    .width(width), .size_full(size_full), .sign_ext(sign_ext),
    .result(result), .zero_flag(zero_flag), .sign_flag(sign_flag),
    .out_valid(out_valid)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] s, input int sh,
                                         input int wd, input bit full, input bit sg);
    logic [63:0] r;
    int n, shm, wdm;
    n = full ? 64 : 32;
    shm = sh % n;
    wdm = wd % n;
    r = '0;
    if (wdm == 0) return r;
    for (int i = 0; i < wdm; i++) r[i] = s[(shm + i) % n];
    if (sg && r[wdm-1])
      for (int i = wdm; i < n; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] s, input int sh, input int wd,
                        input bit full, input bit sg, input bit junk);
    logic [63:0] exp;
    int n, shm, wdm;
    string rq;
    n = full ? 64 : 32;
    shm = sh % n;
    wdm = wd % n;
    exp = model(s, sh, wd, full, sg);
    @(negedge clk);
    in_valid = 1'b1;
    size_full = full;
    sign_ext = sg;
    src = s;
    shift = 6'(sh);
    width = 6'(wd);
    if (!full && junk) begin
      seed = next_rand(seed);
      src[63:32] = seed[63:32];
      shift[5] = seed[3];
      width[5] = seed[9];
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (wdm == 0) rq = "R5";
    else if (!full && junk) rq = "R4";
    else if (shm + wdm > n) rq = "R2";
    else if (sg) rq = "R3";
    else rq = "R1";
    check(rq, result, exp);
    check("R6", {63'd0, zero_flag}, {63'd0, exp == 64'd0});
    check("R7", {63'd0, sign_flag}, {63'd0, exp[n-1]});
    check("R9", {63'd0, out_valid}, 64'd1);
    if (!full) check("R8", {32'd0, result[63:32]}, 64'd0);
  endtask

  initial begin
    #(20ns * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; in_valid = 1'b0; src = '0; shift = '0; width = '0;
    size_full = 1'b1; sign_ext = 1'b0;
    @(negedge clk); in_valid = 1'b1; src = '1; width = 6'd5;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", result, 64'd0);
    rst = 1'b0;

    // corner cases: width 1, width N-1, wrap near top bit, zero width
    run_op(64'h8000_0000_0000_0001, 63, 2, 1, 0, 0);
    run_op(64'h8000_0000_0000_0001, 63, 2, 1, 1, 0);
    run_op(64'hFFFF_FFFF_8000_0000, 31, 1, 0, 1, 0);
    run_op(64'h0000_0000_4000_0001, 30, 31, 0, 1, 0);
    run_op(64'h0123_4567_89AB_CDEF, 62, 63, 1, 1, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 7, 0, 1, 1, 0);
    run_op(64'h0000_0000_FFFF_FFFF, 3, 32, 0, 1, 0);

    // 32-bit sweep, clean and with ignored upper bits
    for (int p = 0; p < 2; p++)
      for (int sh = 0; sh < 32; sh++)
        for (int wd = 0; wd < 32; wd++) begin
          seed = next_rand(seed);
          run_op(seed, sh, wd, 0, (wd + sh + p) % 2 == 1, p == 1);
        end

    // 64-bit sweep, both extension modes
    for (int sg = 0; sg < 2; sg++)
      for (int sh = 0; sh < 64; sh++)
        for (int wd = 0; wd < 64; wd++) begin
          seed = next_rand(seed);
          run_op(seed, sh, wd, 1, sg == 1, 0);
        end

    // hold when in_valid is low
    run_op(64'h0000_0000_0000_00F0, 4, 4, 1, 0, 0);
    held = result;
    @(negedge clk);
    src = '1; shift = 6'd0; width = 6'd40; sign_ext = 1'b1;
    @(negedge clk);
    check("R10", result, held);
    check("R10", {63'd0, zero_flag}, 64'd0);
    check("R9", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R10", result, held);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule